// File: doc/BRIEF.md
# Triple-Redundant Key Record Reader

This block fetches one stored 256-bit symmetric key from a byte-wide nonvolatile memory and checks it before a cipher engine may use it. Each of up to 32 key slots occupies one 128-byte memory page. Within that page, the record is held three times. A record is the slot identifier, a 16-bit CRC and the 32 key bytes.

When a request with a key ID is accepted, the block issues single-byte reads, one at a time. It reads the three copies of each record byte back to back and rebuilds that byte by a bitwise two-of-three majority vote. The voted key bytes feed a running CRC-16. Once all 35 record bytes are voted, the block compares two pairs of values: the voted ID with the requested ID, and the recomputed CRC with the voted stored CRC. It then reports either a valid key or an error.

An out-of-range ID is refused at once and makes no memory access. The memory and the cipher engine are outside the block.

Top module: `key_record_reader`

## Requirements
- R1: After reset, `done`, `key_valid`, `key_error` and `mem_rd` are low, `key_out` is all zeros and `req_ready` is high.
- R2: A request is refused when its ID is 0 or greater than 32. For such a request, `done` and `key_error` are high in the cycle after acceptance, and no `mem_rd` strobe is issued.
- R3: For a valid ID N, the block makes 105 reads. They go in record-byte order b = 0..34, and for each byte the copies go in the order c = 0, 1, 2. Each read is at address (N-1)*128 + 35*c + b. Within a copy, byte 0 is the ID, byte 1 is the CRC high byte, byte 2 is the CRC low byte, and byte 3+k is key byte k. The address is `{N-1, offset}`.
- R4: The memory returns read data two cycles after the cycle in which `mem_rd` is high. Only one read is outstanding at a time, so consecutive strobes are at least three cycles apart. `done` rises 316 cycles after the accepting clock edge.
- R5: Every record byte is rebuilt by a bitwise two-of-three vote across its three copies. The rebuilt byte is correct even when all three copies differ, as long as each bit is wrong in at most one copy.
- R6: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is computed MSB first over the voted key bytes 0 to 31, in that order. If it differs from the voted stored CRC, `key_error` is raised.
- R7: If the voted ID byte differs from the requested ID, `key_error` is raised.
- R8: `key_valid` and `key_error` are never high together. `key_out` is all zeros whenever `key_valid` is low, and in particular after any error.
- R9: On success, `key_valid` goes high and `key_out[8k+7:8k]` holds voted key byte k. `done` is a one-cycle pulse. The result flags and the key are held until the next request is accepted.
- R10: `req_ready` is high only while the block is idle. A `req_valid` raised while the block is busy is ignored: it changes neither the reads nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_id | input | 8 | Requested key ID (1..32) |
| req_ready | output | 1 | Block idle, request will be accepted |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 12 | Memory byte address |
| mem_rdata | input | 8 | Read data, valid two cycles after the strobe |
| done | output | 1 | One-cycle completion pulse |
| key_valid | output | 1 | Key passed the ID and CRC checks |
| key_error | output | 1 | Request refused or record failed its checks |
| key_out | output | 256 | Voted key, zero unless `key_valid` |

## Verification
The bench stores records in a behavioural memory model and uses several fault patterns:
- Clean pages at the first and last slot check the address mapping at both ends.
- Single-copy corruptions scattered across the ID, CRC and key bytes show that voting masks them.
- One key byte whose three copies all differ, each with a disjoint set of flipped bits, separates a bitwise vote from a bytewise vote.
- The same corruption in two copies lets the vote return a wrong byte, which only the CRC catches.
- A CRC that is wrong in every copy, and an ID that is wrong in every copy, check the two comparisons separately.
- Out-of-range IDs and requests raised while the block is busy check refusal and ignoring.

The memory model returns noise outside the two-cycle latency slot, so sampling one cycle early or late is visible.

// File: rtl/key_record_reader.sv
module key_record_reader #(
  parameter int NUM_KEYS   = 32,
  parameter int KEY_BYTES  = 32,
  parameter int PAGE_BYTES = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [7:0]             req_id,
  output logic                   req_ready,
  output logic                   mem_rd,
  output logic [$clog2(NUM_KEYS)+$clog2(PAGE_BYTES)-1:0] mem_addr,
  input  logic [7:0]             mem_rdata,
  output logic                   done,
  output logic                   key_valid,
  output logic                   key_error,
  output logic [8*KEY_BYTES-1:0] key_out
);
  localparam int REC_BYTES = 3 + KEY_BYTES;
  localparam int SLOT_W    = $clog2(NUM_KEYS);
  localparam int PG_W      = $clog2(PAGE_BYTES);
  localparam int BI_W      = $clog2(REC_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_W1, S_W2, S_CHK} state_t;
  state_t st;

  logic [BI_W-1:0]        bidx;
  logic [1:0]             cpy;
  logic [7:0]             c0, c1, id_q, vid;
  logic [15:0]            vcrc, crc;
  logic [8*KEY_BYTES-1:0] kbuf;
  logic [BI_W-1:0]        kidx;
  logic [7:0]             vbyte;
  logic [SLOT_W-1:0]      slot;
  logic [PG_W-1:0]        off;
  logic                   bad_id, accept;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? 16'h1021 : 16'h0000);
    return r;
  endfunction

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign bad_id    = (req_id == 8'd0) || (req_id > 8'(NUM_KEYS));
  assign mem_rd    = (st == S_RD);
  assign slot      = SLOT_W'(id_q - 8'd1);
  assign off       = PG_W'(int'(cpy) * REC_BYTES + int'(bidx));
  assign mem_addr  = {slot, off};
  assign vbyte     = (c0 & c1) | (c0 & mem_rdata) | (c1 & mem_rdata);
  assign kidx      = bidx - BI_W'(3);
  assign key_out   = key_valid ? kbuf : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bidx      <= '0;
      cpy       <= '0;
      c0        <= '0;
      c1        <= '0;
      id_q      <= '0;
      vid       <= '0;
      vcrc      <= '0;
      crc       <= 16'hFFFF;
      kbuf      <= '0;
      done      <= 1'b0;
      key_valid <= 1'b0;
      key_error <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          key_valid <= 1'b0;
          id_q      <= req_id;
          bidx      <= '0;
          cpy       <= '0;
          crc       <= 16'hFFFF;
          if (bad_id) begin
            done      <= 1'b1;
            key_error <= 1'b1;
          end else begin
            key_error <= 1'b0;
            st        <= S_RD;
          end
        end
        S_RD: st <= S_W1;
        S_W1: st <= S_W2;
        S_W2: begin
          if (cpy == 2'd0) c0 <= mem_rdata;
          if (cpy == 2'd1) c1 <= mem_rdata;
          if (cpy == 2'd2) begin
            if (bidx == BI_W'(0))      vid        <= vbyte;
            else if (bidx == BI_W'(1)) vcrc[15:8] <= vbyte;
            else if (bidx == BI_W'(2)) vcrc[7:0]  <= vbyte;
            else begin
              kbuf[8*kidx +: 8] <= vbyte;
              crc               <= crc_step(crc, vbyte);
            end
            cpy <= 2'd0;
            if (bidx == BI_W'(REC_BYTES - 1)) st <= S_CHK;
            else begin
              bidx <= bidx + 1'b1;
              st   <= S_RD;
            end
          end else begin
            cpy <= cpy + 1'b1;
            st  <= S_RD;
          end
        end
        S_CHK: begin
          done      <= 1'b1;
          key_valid <= (vid == id_q) && (vcrc == crc);
          key_error <= !((vid == id_q) && (vcrc == crc));
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_valid && key_error));
  a_r4_gap_one: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_rd) |-> !mem_rd);
  a_r4_gap_two: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_rd, 2) |-> !mem_rd);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_busy_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !req_ready);
  a_r2_refused_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_id) |=> (!mem_rd && done && key_error));
  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && st != S_CHK) |=> ($stable(key_valid) && $stable(key_error) && $stable(key_out)));
endmodule

// File: tb/key_record_reader_tb_top.sv
module key_record_reader_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic [7:0]   req_id;
  logic         req_ready;
  logic         mem_rd;
  logic [11:0]  mem_addr;
  logic [7:0]   mem_rdata;
  logic         done, key_valid, key_error;
  logic [255:0] key_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_rd = -10;
  int exp_q[$];
  logic [7:0] mem [0:4095];
  logic [7:0] d1;

  always #2 clk = ~clk;

  key_record_reader dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_ready(req_ready), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .key_valid(key_valid),
    .key_error(key_error), .key_out(key_out)
  );

  always @(posedge clk) begin
    d1        <= mem_rd ? mem[mem_addr] : 8'hE7;
    mem_rdata <= d1;
  end

  function automatic logic [15:0] ref_crc(input logic [255:0] k);
    logic [15:0] r = 16'hFFFF;
    for (int b = 0; b < 32; b++) begin
      r = r ^ {k[8*b +: 8], 8'h00};
      for (int s = 0; s < 8; s++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    end
    return r;
  endfunction

  function automatic logic [255:0] mk_key(input int seed);
    logic [255:0] k;
    for (int b = 0; b < 32; b++) k[8*b +: 8] = 8'((b * 37 + seed * 11 + 5) ^ (seed << 3));
    return k;
  endfunction

  function automatic int addr_of(input int id, input int c, input int b);
    return (id - 1) * 128 + c * 35 + b;
  endfunction

  task automatic put_rec(input int id, input logic [7:0] idb, input logic [15:0] crc,
                         input logic [255:0] k);
    for (int c = 0; c < 3; c++) begin
      mem[addr_of(id, c, 0)] = idb;
      mem[addr_of(id, c, 1)] = crc[15:8];
      mem[addr_of(id, c, 2)] = crc[7:0];
      for (int b = 0; b < 32; b++) mem[addr_of(id, c, 3 + b)] = k[8*b +: 8];
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n && mem_rd) begin
      int e;
      chk(cyc - last_rd >= 3, "R4 read spacing", 256'(cyc - last_rd), 256'(3));
      last_rd = cyc;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 R3 unexpected read", 256'(mem_addr), 256'(0));
      end else begin
        e = exp_q.pop_front();
        chk(mem_addr == 12'(e), "R3 read address", 256'(mem_addr), 256'(e));
      end
    end
    if (rst_n) chk(key_valid || key_out == '0, "R8 key_out zero when not valid", key_out, 256'(0));
  end

  task automatic run(input int id, input bit exp_ok, input logic [255:0] exp_key,
                     input bit poke, input string tag);
    int lat;
    bit inrange = (id >= 1 && id <= 32);
    if (inrange)
      for (int b = 0; b < 35; b++)
        for (int c = 0; c < 3; c++) exp_q.push_back(addr_of(id, c, b));
    @(negedge clk);
    chk(req_ready, "R10 ready when idle", 256'(req_ready), 256'(1));
    req_valid = 1'b1;
    req_id    = 8'(id);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    if (poke) begin
      req_id    = 8'(id == 3 ? 4 : 3);
      req_valid = 1'b1;
      for (int i = 0; i < 20; i++) begin
        chk(!req_ready, "R10 not ready while busy", 256'(req_ready), 256'(0));
        @(posedge clk);
        @(negedge clk);
        lat++;
      end
      req_valid = 1'b0;
    end
    while (!done && lat < 2000) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    chk(lat == (inrange ? 316 : 0), {tag, " R4 done latency"}, 256'(lat), 256'(inrange ? 316 : 0));
    chk(key_valid == exp_ok && key_error == !exp_ok, {tag, " R9 flags"},
        256'({key_valid, key_error}), 256'({exp_ok, !exp_ok}));
    chk(key_out == (exp_ok ? exp_key : '0), {tag, " R9 key_out"}, key_out, exp_ok ? exp_key : '0);
    chk(exp_q.size() == 0, {tag, " R3 read count"}, 256'(exp_q.size()), 256'(0));
    @(posedge clk);
    @(negedge clk);
    chk(!done, {tag, " R9 done pulse"}, 256'(done), 256'(0));
    chk(key_valid == exp_ok && key_out == (exp_ok ? exp_key : '0), {tag, " R9 result held"},
        key_out, exp_ok ? exp_key : '0);
  endtask

  initial begin
    logic [255:0] k;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    rst_n = 1'b0; req_valid = 1'b0; req_id = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done && !key_valid && !key_error && !mem_rd && key_out == '0 && req_ready,
        "R1 reset state", 256'({done, key_valid, key_error, mem_rd, req_ready}), 256'(1));
    rst_n = 1'b1;

    run(0, 1'b0, '0, 1'b0, "R2 id0");
    run(33, 1'b0, '0, 1'b0, "R2 id33");

    for (int id = 1; id <= 32; id++) begin
      k = mk_key(id);
      put_rec(id, 8'(id), ref_crc(k), k);
    end
    run(1, 1'b1, mk_key(1), 1'b0, "R3 clean slot1");
    run(32, 1'b1, mk_key(32), 1'b0, "R3 clean slot32");

    mem[addr_of(5, 0, 13)] ^= 8'hFF;
    mem[addr_of(5, 1, 23)] ^= 8'h5A;
    mem[addr_of(5, 2, 0)]  ^= 8'h21;
    mem[addr_of(5, 1, 1)]  ^= 8'h80;
    mem[addr_of(5, 0, 2)]  ^= 8'h01;
    run(5, 1'b1, mk_key(5), 1'b0, "R5 single-copy faults");

    mem[addr_of(7, 0, 18)] ^= 8'h0F;
    mem[addr_of(7, 1, 18)] ^= 8'hF0;
    mem[addr_of(7, 2, 18)] ^= 8'h00;
    mem[addr_of(7, 0, 34)] ^= 8'hC3;
    mem[addr_of(7, 2, 34)] ^= 8'h3C;
    run(7, 1'b1, mk_key(7), 1'b1, "R5 R10 bitwise vote busy poke");

    for (int c = 0; c < 3; c++) mem[addr_of(9, c, 2)] ^= 8'h01;
    run(9, 1'b0, '0, 1'b0, "R6 bad crc");

    for (int c = 0; c < 3; c++) mem[addr_of(10, c, 0)] = 8'd11;
    run(10, 1'b0, '0, 1'b0, "R7 id mismatch");

    mem[addr_of(11, 0, 30)] ^= 8'h01;
    mem[addr_of(11, 1, 30)] ^= 8'h01;
    run(11, 1'b0, '0, 1'b0, "R6 R8 double-copy fault");

    run(12, 1'b1, mk_key(12), 1'b0, "R9 recovery after error");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule